// File: doc/BRIEF.md
# Relative Branch Condition Evaluator

This block decides whether a conditional relative branch is taken. It also works out the address where execution goes next. A request holds:
- the branch opcode byte;
- the four status flags;
- a status bit that says the low three bits of the scratchpad pointer are all ones;
- the address of the byte after the displacement;
- the signed 8-bit displacement.

The block returns:
- whether the opcode is a relative branch at all;
- whether the branch is taken;
- the next address;
- the cost of the instruction in half-cycles.

The opcode itself carries the condition as a flag mask. The flag positions in that mask are sign (bit 0), carry (bit 1), zero (bit 2) and overflow (bit 3). A true-form branch is taken if any selected flag is set. A false-form branch is taken only if every selected flag is clear, so a false-form branch with an empty mask always branches. One separate opcode branches on the scratchpad pointer status instead of the flags.

Requests and results travel over valid/ready streams, with one register stage between them:
- A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high.
- Its result is presented on `out_valid` from the next cycle.
- `in_ready` is high whenever the output register is empty or its content is leaving on that same edge. A full output register that the sink holds off with `out_ready` low therefore stalls the input side.
- While a result waits under back-pressure, it stays unchanged.

Top module: `brx_eval`

## Requirements
- R1: Opcodes 0x80 to 0x87 (true form, mask = opcode bits 2:0 over flags bit0 sign, bit1 carry, bit2 zero) are taken exactly when the mask AND the flags is nonzero; 0x80 is never taken.
- R2: Opcodes 0x90 to 0x9F (false form, mask = opcode bits 3:0 over flags bit0 sign, bit1 carry, bit2 zero, bit3 overflow) are taken exactly when the mask AND the flags is zero; 0x90 is always taken.
- R3: Opcode 0x8F is taken exactly when `in_ptr_low_full` is 0.
- R4: A taken branch yields `out_target` = `in_next_addr` − 1 + sign-extended `in_disp`, modulo 2^16. A not-taken branch yields `out_target` = `in_next_addr`.
- R5: For a recognised branch, `out_cost` is 7 half-cycles when it is taken and 6 when it is not.
- R6: Any other opcode gives `out_known` = 0, `out_taken` = 0, `out_target` = `in_next_addr` and `out_cost` = 0. Opcodes 0x88 to 0x8E are in this group.
- R7: An accepted request appears with `out_valid` = 1 in the following cycle. `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1.
- R8: While `out_valid` = 1 and `out_ready` = 0, every output field is held, and `out_valid` stays 1 on the next cycle.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_opcode | input | 8 | Branch opcode byte |
| in_flags | input | 4 | Flags: bit0 sign, bit1 carry, bit2 zero, bit3 overflow |
| in_ptr_low_full | input | 1 | Scratchpad pointer low three bits are all ones |
| in_next_addr | input | 16 | Address of the byte after the displacement |
| in_disp | input | 8 | Signed displacement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink accepts the result |
| out_known | output | 1 | Opcode is a relative branch |
| out_taken | output | 1 | Branch taken |
| out_target | output | 16 | Next address |
| out_cost | output | 4 | Cost in half-cycles |

## Verification
The properties assume three things about the inputs:
- the request fields are meaningful only in a cycle where `in_valid` is high;
- the sink may lower `out_ready` at any time;
- the request fields hold defined values whenever a request is accepted.

The stimulus drives every field to a defined value before raising `in_valid`, and changes inputs only on falling edges. It also holds `out_ready` low across several cycles in one phase, so the hold and stall properties are exercised and not only trivially met.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_TRUE  = 2'd1,
    BK_FALSE = 2'd2,
    BK_PTR   = 2'd3
  } brx_kind_e;

  localparam int OPC_W      = 8;
  localparam int FLAG_W     = 4;
  localparam int TRUE_MSK_W = 3;
  localparam logic [OPC_W-1:0] OPC_PTR = 8'h8F;
  localparam logic [4:0] TRUE_HI  = 5'b10000;
  localparam logic [3:0] FALSE_HI = 4'b1001;
endpackage

// File: rtl/brx_decode.sv
module brx_decode
  import brx_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  output brx_kind_e         kind,
  output logic [FLAG_W-1:0] mask
);
  always_comb begin
    kind = BK_NONE;
    mask = '0;
    if (opcode == OPC_PTR) begin
      kind = BK_PTR;
    end else if (opcode[7:3] == TRUE_HI) begin
      kind = BK_TRUE;
      mask = {{(FLAG_W-TRUE_MSK_W){1'b0}}, opcode[TRUE_MSK_W-1:0]};
    end else if (opcode[7:4] == FALSE_HI) begin
      kind = BK_FALSE;
      mask = opcode[FLAG_W-1:0];
    end
  end
endmodule

// File: rtl/brx_cond.sv
module brx_cond
  import brx_pkg::*;
(
  input  brx_kind_e         kind,
  input  logic [FLAG_W-1:0] mask,
  input  logic [FLAG_W-1:0] flags,
  input  logic              ptr_full,
  output logic              known,
  output logic              taken
);
  logic [FLAG_W-1:0] hit;
  logic              any_hit;

  for (genvar b = 0; b < FLAG_W; b++) begin : g_hit
    assign hit[b] = mask[b] & flags[b];
  end
  assign any_hit = |hit;

  always_comb begin
    known = (kind != BK_NONE);
    unique case (kind)
      BK_TRUE:  taken = any_hit;
      BK_FALSE: taken = ~any_hit;
      BK_PTR:   taken = ~ptr_full;
      default:  taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/brx_target.sv
module brx_target #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [DISP_W-1:0] disp,
  input  logic              taken,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - DISP_W;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] base;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign base     = next_addr - ADDR_W'(1);
  assign target   = taken ? (base + disp_ext) : next_addr;
endmodule

// File: rtl/brx_eval.sv
module brx_eval
  import brx_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DISP_W     = 8,
  parameter int COST_W     = 4,
  parameter int COST_TAKEN = 7,
  parameter int COST_SKIP  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic [3:0]        in_flags,
  input  logic              in_ptr_low_full,
  input  logic [ADDR_W-1:0] in_next_addr,
  input  logic [DISP_W-1:0] in_disp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_known,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_target,
  output logic [COST_W-1:0] out_cost
);
  brx_kind_e         kind;
  logic [FLAG_W-1:0] mask;
  logic              c_known, c_taken;
  logic [ADDR_W-1:0] c_target;
  logic [COST_W-1:0] c_cost;
  logic              accept;

  brx_decode u_dec (.opcode(in_opcode), .kind(kind), .mask(mask));

  brx_cond u_cond (
    .kind(kind), .mask(mask), .flags(in_flags),
    .ptr_full(in_ptr_low_full), .known(c_known), .taken(c_taken)
  );

  brx_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .next_addr(in_next_addr), .disp(in_disp), .taken(c_taken), .target(c_target)
  );

  always_comb begin
    if (!c_known)     c_cost = '0;
    else if (c_taken) c_cost = COST_W'(COST_TAKEN);
    else              c_cost = COST_W'(COST_SKIP);
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_known  <= 1'b0;
      out_taken  <= 1'b0;
      out_target <= '0;
      out_cost   <= '0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_known  <= c_known;
        out_taken  <= c_taken;
        out_target <= c_target;
        out_cost   <= c_cost;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/brx_eval_chk.sv
module brx_eval_chk #(
  parameter int ADDR_W     = 16,
  parameter int COST_W     = 4,
  parameter int COST_TAKEN = 7,
  parameter int COST_SKIP  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_opcode,
  input logic [ADDR_W-1:0] in_next_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_known,
  input logic              out_taken,
  input logic [ADDR_W-1:0] out_target,
  input logic [COST_W-1:0] out_cost
);
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_target) && $stable(out_taken)
      && $stable(out_known) && $stable(out_cost)); // R8
  AST_TAKEN_COST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken |-> out_cost == COST_W'(COST_TAKEN)); // R5
  AST_SKIP_COST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_known && !out_taken |-> out_cost == COST_W'(COST_SKIP)); // R5
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_known |-> !out_taken && out_cost == '0); // R6
  AST_EMPTY_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode == 8'h90 |=> out_valid && out_taken); // R2
  AST_EMPTY_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode == 8'h80 |=>
      !out_taken && out_target == $past(in_next_addr)); // R1
endmodule

bind brx_eval brx_eval_chk #(
  .ADDR_W(ADDR_W), .COST_W(COST_W), .COST_TAKEN(COST_TAKEN), .COST_SKIP(COST_SKIP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .in_next_addr(in_next_addr), .out_valid(out_valid),
  .out_ready(out_ready), .out_known(out_known), .out_taken(out_taken),
  .out_target(out_target), .out_cost(out_cost)
);

// File: tb/brx_eval_test.sv
module brx_eval_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [3:0]  in_flags = '0;
  logic        in_ptr_low_full = 1'b0;
  logic [15:0] in_next_addr = '0;
  logic [7:0]  in_disp = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_known;
  logic        out_taken;
  logic [15:0] out_target;
  logic [3:0]  out_cost;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  brx_eval uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_flags(in_flags), .in_ptr_low_full(in_ptr_low_full),
    .in_next_addr(in_next_addr), .in_disp(in_disp), .out_valid(out_valid),
    .out_ready(out_ready), .out_known(out_known), .out_taken(out_taken),
    .out_target(out_target), .out_cost(out_cost)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected-value model written from the requirement text
  function automatic logic exp_known(input logic [7:0] op);
    return (op[7:3] == 5'b10000) || (op[7:4] == 4'b1001) || (op == 8'h8F);
  endfunction

  function automatic logic exp_taken(input logic [7:0] op, input logic [3:0] fl, input logic pf);
    if (op == 8'h8F) return !pf;
    if (op[7:3] == 5'b10000) return ((op[2:0] & fl[2:0]) != 3'b000);
    if (op[7:4] == 4'b1001) return ((op[3:0] & fl) == 4'b0000);
    return 1'b0;
  endfunction

  function automatic string cond_tag(input logic [7:0] op);
    if (op == 8'h8F) return "R3";
    if (op[7:3] == 5'b10000) return "R1";
    if (op[7:4] == 4'b1001) return "R2";
    return "R6";
  endfunction

  task automatic run_one(input logic [7:0] op, input logic [3:0] fl, input logic pf,
                         input logic [15:0] na, input logic [7:0] d);
    logic        tk;
    logic [15:0] tgt;
    logic [3:0]  cst;
    tk  = exp_taken(op, fl, pf);
    tgt = tk ? 16'(int'(na) - 1 + int'($signed(d))) : na;
    cst = !exp_known(op) ? 4'd0 : (tk ? 4'd7 : 4'd6);
    @(negedge clk);
    in_opcode = op; in_flags = fl; in_ptr_low_full = pf;
    in_next_addr = na; in_disp = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 out_valid", 32'(out_valid), 32'd1);
    check({cond_tag(op), " known"}, 32'(out_known), 32'(exp_known(op)));
    check({cond_tag(op), " taken"}, 32'(out_taken), 32'(tk));
    check("R4 target", 32'(out_target), 32'(tgt));
    check(exp_known(op) ? "R5 cost" : "R6 cost", 32'(out_cost), 32'(cst));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", 32'(out_valid), 32'd0);
    check("R9 in_ready after reset", 32'(in_ready), 32'd1);

    // Sweep every opcode, flag pattern and pointer status
    for (int op = 0; op < 256; op++)
      for (int fl = 0; fl < 16; fl++)
        for (int pf = 0; pf < 2; pf++)
          run_one(8'(op), 4'(fl), 1'(pf), 16'(op * 257 + fl * 4099 + pf * 31),
                  8'(op * 37 + fl * 11 + pf * 5));

    // R4 wrap corners
    run_one(8'h90, 4'h0, 1'b0, 16'h0000, 8'h80);
    check("R4 wrap low", 32'(out_target), 32'h0000FF7F);
    run_one(8'h90, 4'h0, 1'b0, 16'hFFF0, 8'h7F);
    check("R4 wrap high", 32'(out_target), 32'h0000006E);
    run_one(8'h8F, 4'h0, 1'b1, 16'h1234, 8'h10);
    check("R3 pointer full skip", 32'(out_target), 32'h00001234);

    // R8 / R7 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_opcode = 8'h82; in_flags = 4'h2; in_ptr_low_full = 1'b0;
    in_next_addr = 16'h4000; in_disp = 8'hFE; in_valid = 1'b1;
    @(negedge clk);
    check("R7 accepted under stall", 32'(out_valid), 32'd1);
    in_opcode = 8'h94; in_flags = 4'h4; in_next_addr = 16'h5000; in_disp = 8'h03;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 held valid", 32'(out_valid), 32'd1);
      check("R8 held target", 32'(out_target), 32'h00003FFD);
      check("R8 held taken", 32'(out_taken), 32'd1);
      check("R7 in_ready low", 32'(in_ready), 32'd0);
    end
    out_ready = 1'b1;
    #1;
    check("R7 in_ready follows out_ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 second result", 32'(out_target), 32'h00005000);
    check("R2 zero set no branch", 32'(out_taken), 32'd0);
    check("R5 skip cost", 32'(out_cost), 32'd6);
    @(negedge clk);
    check("R7 drained", 32'(out_valid), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule